// File: doc/BRIEF.md
# Element Step Sequencer

This block walks the element and sub-element positions of one vectorised instruction. A source nest produces an element index and a sub-element index, and a destination nest produces its own pair. The two nests are held separately so that later stages, for example twin predication, can use them apart. Each nest is a two-level loop over a vector length `vl_i` and a sub-vector length `subvl_i`. Each nest has its own order flag: `pack_i` for the source and `unpack_i` for the destination. Either flag swaps which of that nest's two loops is the inner one.

In horizontal mode the sequencer issues one position per cycle while `run_i` is high. In vertical-first mode (`vfirst_i` high) it moves only on a cycle with `step_i` high, and `run_i` has no effect. The step registers are the live copy of the state register's step fields. On the final position the block flags `last_o` and `done_o`, and the steps then return to zero for the next instruction. A vector length of zero issues nothing and completes at once.

The configuration inputs (`vl_i`, `subvl_i`, `pack_i`, `unpack_i`) must be held steady from the first issued position until `done_o`.

Top module: `elem_step_seq`

## Requirements
- R1: With `pack_i` low, the source element index (`src_elem_o`) runs 0..VL-1 as the outer loop. The source sub-index (`src_sub_o`) runs 0..SUBVL-1 as the inner loop, so position k has element k/SUBVL and sub-index k%SUBVL.
- R2: The destination indices (`dst_elem_o`, `dst_sub_o`) cover the same ranges as the source indices. They are computed by their own nest, under `unpack_i`, independently of `pack_i`.
- R3: With `pack_i` high, the source nest is inverted: the element index is the inner loop. Position k has element k%VL and sub-index k/VL.
- R4: With `unpack_i` high, the destination nest is inverted in the same way.
- R5: With `vfirst_i` low, a cycle with `run_i` high issues the current position (`valid_o` high) and advances both nests at the clock edge. A cycle with `run_i` low issues nothing and leaves all indices unchanged.
- R6: With `vfirst_i` high, the nests advance only on a cycle with `step_i` high. In that mode `run_i` has no effect, and the indices stay constant while `step_i` is low.
- R7: `last_o` and `done_o` are high in the cycle that issues position VL*SUBVL-1, where both nests are at their final index. After that edge, all four indices read zero.
- R8: With `vl_i` equal to 0, `valid_o` and `last_o` stay low. `done_o` is high on the first advancing cycle, and the indices stay at zero.
- R9: After the asynchronous reset `rst_ni` is released, all four indices are zero and no position has yet been issued.
- R10: `subvl_i` carries SUBVL directly as a value from 1 to 4. The sub-indices are 2 bits wide, and SUBVL=1 keeps them at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vl_i | input | VL_W (7) | Vector length |
| subvl_i | input | SUB_W+1 (3) | Sub-vector length, 1..4 |
| pack_i | input | 1 | Invert source loop nesting |
| unpack_i | input | 1 | Invert destination loop nesting |
| vfirst_i | input | 1 | Vertical-first mode |
| run_i | input | 1 | Issue enable in horizontal mode |
| step_i | input | 1 | Explicit step request in vertical-first mode |
| valid_o | output | 1 | A position is issued this cycle |
| last_o | output | 1 | The issued position is the final one |
| done_o | output | 1 | The sequence completes this cycle |
| src_elem_o | output | VL_W | Source element index |
| src_sub_o | output | SUB_W (2) | Source sub-element index |
| dst_elem_o | output | VL_W | Destination element index |
| dst_sub_o | output | SUB_W | Destination sub-element index |

## Verification
The indices are the state itself, so a wrong wrap or a wrong carry is visible on the index ports in the cycle after the faulty edge. A wrong loop order differs from the expected sequence at the second issued position, unless VL or SUBVL is 1. A missed return to zero appears only at the start of the next sequence, and a `done_o` that arrives early or late shows up against the expected count of VL*SUBVL positions.

// File: rtl/elem_step_pkg.sv
package elem_step_pkg;
  typedef enum logic {
    ORD_SUB_INNER  = 1'b0,
    ORD_ELEM_INNER = 1'b1
  } nest_order_e;
endpackage

// File: rtl/step_nest.sv
module step_nest
  import elem_step_pkg::*;
#(
  parameter int unsigned VL_W  = 7,
  parameter int unsigned SUB_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             wrap_i,
  input  nest_order_e      order_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [SUB_W-1:0] sub_last_i,
  output logic [VL_W-1:0]  elem_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             at_end_o
);
  logic [VL_W-1:0]  elem_q, elem_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [VL_W-1:0]  elem_last;
  logic             elem_end, sub_end;

  assign elem_last = vl_i - VL_W'(1);
  assign elem_end  = (elem_q == elem_last);
  assign sub_end   = (sub_q == sub_last_i);
  assign at_end_o  = elem_end && sub_end;

  always_comb begin
    elem_d = elem_q;
    sub_d  = sub_q;
    if (wrap_i) begin
      elem_d = '0;
      sub_d  = '0;
    end else if (adv_i) begin
      if (order_i == ORD_SUB_INNER) begin
        if (sub_end) begin
          sub_d  = '0;
          elem_d = elem_q + VL_W'(1);
        end else begin
          sub_d = sub_q + SUB_W'(1);
        end
      end else begin
        if (elem_end) begin
          elem_d = '0;
          sub_d  = sub_q + SUB_W'(1);
        end else begin
          elem_d = elem_q + VL_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elem_q <= '0;
      sub_q  <= '0;
    end else begin
      elem_q <= elem_d;
      sub_q  <= sub_d;
    end
  end

  assign elem_o = elem_q;
  assign sub_o  = sub_q;

  AST_ELEM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vl_i != '0) |-> (elem_q < vl_i)); // R1
  AST_SUB_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_q <= sub_last_i); // R10
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (elem_q == '0) && (sub_q == '0)); // R7
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl (
  input  logic vfirst_i,
  input  logic run_i,
  input  logic step_i,
  input  logic vl_zero_i,
  input  logic src_end_i,
  input  logic dst_end_i,
  output logic adv_o,
  output logic valid_o,
  output logic last_o,
  output logic done_o
);
  logic fin;

  // vertical-first: only an explicit step moves the nests
  assign adv_o   = vfirst_i ? step_i : run_i;
  assign fin     = src_end_i && dst_end_i;
  assign valid_o = adv_o && !vl_zero_i;
  assign last_o  = valid_o && fin;
  assign done_o  = adv_o && (vl_zero_i || fin);
endmodule

// File: rtl/elem_step_seq.sv
module elem_step_seq
  import elem_step_pkg::*;
#(
  parameter int unsigned VL_W      = 7,
  parameter int unsigned SUBVL_MAX = 4,
  localparam int unsigned SUB_W    = $clog2(SUBVL_MAX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [SUB_W:0]   subvl_i,
  input  logic             pack_i,
  input  logic             unpack_i,
  input  logic             vfirst_i,
  input  logic             run_i,
  input  logic             step_i,
  output logic             valid_o,
  output logic             last_o,
  output logic             done_o,
  output logic [VL_W-1:0]  src_elem_o,
  output logic [SUB_W-1:0] src_sub_o,
  output logic [VL_W-1:0]  dst_elem_o,
  output logic [SUB_W-1:0] dst_sub_o
);
  logic             adv, src_end, dst_end, vl_zero;
  logic [SUB_W:0]   sub_last_w;
  logic [SUB_W-1:0] sub_last;

  assign vl_zero    = (vl_i == '0);
  assign sub_last_w = subvl_i - (SUB_W+1)'(1);
  assign sub_last   = sub_last_w[SUB_W-1:0];

  step_ctrl u_ctrl (
    .vfirst_i  (vfirst_i),
    .run_i     (run_i),
    .step_i    (step_i),
    .vl_zero_i (vl_zero),
    .src_end_i (src_end),
    .dst_end_i (dst_end),
    .adv_o     (adv),
    .valid_o   (valid_o),
    .last_o    (last_o),
    .done_o    (done_o)
  );

  step_nest #(.VL_W(VL_W), .SUB_W(SUB_W)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .wrap_i     (done_o),
    .order_i    (pack_i ? ORD_ELEM_INNER : ORD_SUB_INNER),
    .vl_i       (vl_i),
    .sub_last_i (sub_last),
    .elem_o     (src_elem_o),
    .sub_o      (src_sub_o),
    .at_end_o   (src_end)
  );

  step_nest #(.VL_W(VL_W), .SUB_W(SUB_W)) u_dst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .wrap_i     (done_o),
    .order_i    (unpack_i ? ORD_ELEM_INNER : ORD_SUB_INNER),
    .vl_i       (vl_i),
    .sub_last_i (sub_last),
    .elem_o     (dst_elem_o),
    .sub_o      (dst_sub_o),
    .at_end_o   (dst_end)
  );

  AST_NEST_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_end == dst_end); // R2
  AST_VF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vfirst_i && !step_i) |=> $stable(src_elem_o) && $stable(src_sub_o)
                              && $stable(dst_elem_o) && $stable(dst_sub_o)); // R6
  AST_VL0_NOISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_zero |-> !valid_o && !last_o); // R8
  AST_LAST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> done_o); // R7
endmodule

// File: tb/elem_step_seq_test.sv
`timescale 1ns/1ps
module elem_step_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] vl = '0;
  logic [2:0] subvl = 3'd1;
  logic       pack = 1'b0, unpack = 1'b0, vfirst = 1'b0, run = 1'b0, step = 1'b0;
  logic       valid, last, done;
  logic [6:0] src_elem, dst_elem;
  logic [1:0] src_sub, dst_sub;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  elem_step_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .vl_i(vl), .subvl_i(subvl),
    .pack_i(pack), .unpack_i(unpack), .vfirst_i(vfirst),
    .run_i(run), .step_i(step), .valid_o(valid), .last_o(last),
    .done_o(done), .src_elem_o(src_elem), .src_sub_o(src_sub),
    .dst_elem_o(dst_elem), .dst_sub_o(dst_sub)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_zero(string req);
    chk(req, src_elem, 0); chk(req, src_sub, 0);
    chk(req, dst_elem, 0); chk(req, dst_sub, 0);
  endtask

  // R1 R2 R3 R4 R5 R7 R10: full sequence, expected from closed form
  task automatic run_seq(int n_vl, int n_sv, bit pk, bit up, bit vf);
    int n = n_vl * n_sv;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      vl = 7'(n_vl); subvl = 3'(n_sv); pack = pk; unpack = up; vfirst = vf;
      run = !vf; step = vf;
      #1;
      chk("R5 valid", valid, 1);
      chk(pk ? "R3 src elem" : "R1 src elem", src_elem, pk ? k % n_vl : k / n_sv);
      chk(pk ? "R3 src sub" : "R10 src sub", src_sub, pk ? k / n_vl : k % n_sv);
      chk(up ? "R4 dst elem" : "R2 dst elem", dst_elem, up ? k % n_vl : k / n_sv);
      chk(up ? "R4 dst sub" : "R2 dst sub", dst_sub, up ? k / n_vl : k % n_sv);
      chk("R7 last", last, (k == n-1) ? 1 : 0);
      chk("R7 done", done, (k == n-1) ? 1 : 0);
    end
    @(negedge clk);
    run = 1'b0; step = 1'b0;
    #1;
    chk_zero("R7 wrap to zero");
    chk("R5 idle valid", valid, 0);
  endtask

  task automatic t_reset;
    #1;
    chk_zero("R9 reset");
    chk("R9 valid", valid, 0);
  endtask

  task automatic t_vl_zero;
    @(negedge clk);
    vl = '0; subvl = 3'd3; vfirst = 1'b0; run = 1'b1;
    #1;
    chk("R8 valid", valid, 0);
    chk("R8 last", last, 0);
    chk("R8 done", done, 1);
    @(negedge clk);
    run = 1'b0;
    #1;
    chk_zero("R8 steps");
  endtask

  task automatic t_run_hold;
    @(negedge clk);
    vl = 7'd3; subvl = 3'd2; pack = 1'b0; unpack = 1'b1; vfirst = 1'b0; run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    #1;
    chk("R5 hold src sub", src_sub, 1);
    chk("R5 hold dst elem", dst_elem, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R5 hold valid", valid, 0);
      chk("R5 hold src sub", src_sub, 1);
      chk("R5 hold dst elem", dst_elem, 1);
    end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); run = 1'b1;
    end
    #1;
    chk("R7 done after hold", done, 1);
    @(negedge clk); run = 1'b0; #1;
    chk_zero("R7 zero after hold");
  endtask

  task automatic t_vfirst_hold;
    @(negedge clk);
    vl = 7'd4; subvl = 3'd2; pack = 1'b1; unpack = 1'b0; vfirst = 1'b1;
    run = 1'b1; step = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R6 no issue", valid, 0);
      chk_zero("R6 held");
    end
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    #1;
    chk("R6 stepped src elem", src_elem, 1);
    chk("R6 stepped dst sub", dst_sub, 1);
    @(negedge clk); #1;
    chk("R6 held src elem", src_elem, 1);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); step = 1'b1;
    end
    #1;
    chk("R6 done", done, 1);
    @(negedge clk); step = 1'b0; run = 1'b0; vfirst = 1'b0; #1;
    chk_zero("R6 zero");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (completion)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    #12 rst_n = 1'b1;
    t_reset();
    run_seq(5, 3, 1'b0, 1'b0, 1'b0);
    run_seq(5, 3, 1'b1, 1'b0, 1'b0);
    run_seq(4, 2, 1'b0, 1'b1, 1'b0);
    run_seq(3, 4, 1'b1, 1'b1, 1'b0);
    run_seq(6, 1, 1'b1, 1'b0, 1'b0);
    run_seq(1, 4, 1'b0, 1'b1, 1'b0);
    run_seq(64, 4, 1'b0, 1'b1, 1'b0);
    run_seq(3, 3, 1'b1, 1'b0, 1'b1);
    t_vl_zero();
    t_run_hold();
    t_vfirst_hold();
    run_seq(2, 2, 1'b0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule